// File: doc/BRIEF.md
# Bunch Gate Sequencer

This block runs on the accelerator RF clock and produces the timing for a pair of fast gated integrators and the digitizers that sample them. A once-per-turn sync marker restarts a bucket counter. Every live bunch slot carries its own programmed delay in RF buckets. When the counter reaches a slot's delay, the block plays out a fixed sequence. The narrow and wide integrate gates open together. The narrow gate closes after one bucket and the wide gate after a programmed number of buckets. A one-cycle digitizer trigger follows, then a three-cycle integrator reset. Triggers for odd-numbered bunches go out on one line and triggers for even-numbered bunches on a second line.

Turns alternate between bunch turns and baseline turns. On a baseline turn no bunch slot fires. Instead, one sequence runs at a programmed zero-sample time, and a separate zero time is held for each of the two beam modes. Proton mode uses up to twelve slots. Antiproton mode uses only the first four. An enable mask and a batch length narrow the live set further. A slot whose sequence would start while the previous one is still running is dropped, and a sticky error flag is raised.

Top module: `bunchGateSeq`

## Requirements
- R1: The clock edge that samples syncMarker high is edge 0 of a turn. A slot with delay D raises narrowGate in the cycle after edge D+2 and in no other cycle of that sequence.
- R2: wideGate rises together with narrowGate and stays high for W cycles, where W is wideWidth. A wideWidth of 0 acts as 1.
- R3: In the cycle right after wideGate falls, a trigger is high for exactly one cycle. integReset is then high for the next three cycles.
- R4: Slot index i (0-based) is bunch number i+1. Triggers for odd bunch numbers (even i) and for baseline samples go to trigOdd. Triggers for even bunch numbers go to trigEven. The two lines are never high together.
- R5: baseTurn is 0 after reset and toggles on every sync marker. Bunch slots fire only while baseTurn is 0.
- R6: While baseTurn is 1, exactly one sequence runs per turn. It starts at delay protonZero when antiMode is 0 and at delay pbarZero when antiMode is 1.
- R7: Slot i is live only when slotEnable[i] is 1, i < batchLen, and, when antiMode is 1, i < 4. A slot that is not live produces no gates.
- R8: A start is accepted only when the previous sequence has finished, which needs a start spacing of at least W+5. A start that comes earlier is dropped, and so are all but the lowest-index slot among simultaneous starts. In both cases overlapErr goes to 1 after the following edge and stays there until reset.
- R9: During reset and until the first sync marker, all outputs are 0 and no sequence runs, whatever delays are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF bucket clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncMarker | input | 1 | Once-per-turn beam sync marker |
| antiMode | input | 1 | 1 selects the four-slot antiproton mode |
| slotEnable | input | 12 | Per-slot enable mask |
| batchLen | input | 4 | Number of slots in the batch (1 to 15) |
| wideWidth | input | 4 | Wide gate width in buckets |
| slotDelays | input | 144 | Per-slot delay, slot i in bits [12i+11:12i] |
| protonZero | input | 12 | Baseline sample delay in proton mode |
| pbarZero | input | 12 | Baseline sample delay in antiproton mode |
| narrowGate | output | 1 | One-bucket integrate gate |
| wideGate | output | 1 | Programmable-width integrate gate |
| trigOdd | output | 1 | Digitizer trigger for odd bunches and baseline |
| trigEven | output | 1 | Digitizer trigger for even bunches |
| integReset | output | 1 | Integrator reset pulse |
| baseTurn | output | 1 | 1 during baseline turns |
| overlapErr | output | 1 | Sticky overlap error flag |

## Verification
A model in the bench predicts every output for every cycle of a turn. The stimulus comes in four kinds. Directed full twelve-slot batches with widely spaced delays show the gate, trigger and reset positions, and the odd/even routing. Masked, shortened and antiproton batches separate live slots from silent ones. Spacing exactly at the W+5 limit, one bucket inside it, and equal delays separate a legal close spacing from a suppressed overlap. Random configurations with random widths, masks, spacings and zero times mix bunch turns and baseline turns, so the alternation and the choice of zero time per mode are checked against each other.

// File: rtl/bunchSeqPkg.sv
package bunchSeqPkg;
  typedef struct packed {
    logic narrow;
    logic wide;
    logic trig;
    logic intReset;
    logic chanEven;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WIDE,
    S_TRIG,
    S_RST
  } seqState_t;
endpackage

// File: rtl/bunchSeqPath.sv
module bunchSeqPath
  import bunchSeqPkg::*;
#(
  parameter int NSLOT      = 12,
  parameter int PBAR_SLOTS = 4,
  parameter int CW         = 12,
  parameter int BLW        = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncMarker,
  input  logic               antiMode,
  input  logic [NSLOT-1:0]   slotEnable,
  input  logic [BLW-1:0]     batchLen,
  input  logic [NSLOT*CW-1:0] slotDelays,
  input  logic [CW-1:0]      protonZero,
  input  logic [CW-1:0]      pbarZero,
  input  seqStrobe_t         strobe,
  output logic [NSLOT-1:0]   bunchHit,
  output logic               zeroHit,
  output logic               baseTurn,
  output logic               narrowGate,
  output logic               wideGate,
  output logic               trigOdd,
  output logic               trigEven,
  output logic               integReset
);
  logic          running;
  logic [CW-1:0] turnCount;
  logic          canHit;
  logic [CW-1:0] zeroTime;
  logic [NSLOT-1:0] slotLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      turnCount <= '0;
      baseTurn  <= 1'b0;
    end else if (syncMarker) begin
      running   <= 1'b1;
      turnCount <= '0;
      baseTurn  <= ~baseTurn;
    end else if (turnCount != '1) begin
      turnCount <= turnCount + CW'(1);
    end
  end

  assign canHit   = running && (turnCount != '1);
  assign zeroTime = antiMode ? pbarZero : protonZero;
  assign zeroHit  = canHit && baseTurn && (turnCount == zeroTime);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int unsigned IDX = i;
    assign slotLive[i] = slotEnable[i] && (IDX < 32'(batchLen)) &&
                         (!antiMode || (IDX < PBAR_SLOTS));
    assign bunchHit[i] = canHit && !baseTurn && slotLive[i] &&
                         (turnCount == slotDelays[i*CW +: CW]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      narrowGate <= 1'b0;
      wideGate   <= 1'b0;
      trigOdd    <= 1'b0;
      trigEven   <= 1'b0;
      integReset <= 1'b0;
    end else begin
      narrowGate <= strobe.narrow;
      wideGate   <= strobe.wide;
      trigOdd    <= strobe.trig && !strobe.chanEven;
      trigEven   <= strobe.trig && strobe.chanEven;
      integReset <= strobe.intReset;
    end
  end

  a_r1_narrow_single: assert property (@(posedge clk) disable iff (!rstN)
    narrowGate |=> !narrowGate);
  a_r2_narrow_in_wide: assert property (@(posedge clk) disable iff (!rstN)
    narrowGate |-> wideGate);
  a_r3_trig_after_wide: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wideGate) |-> (trigOdd || trigEven));
  a_r3_reset_after_trig: assert property (@(posedge clk) disable iff (!rstN)
    (trigOdd || trigEven) |=> integReset);
  a_r4_trig_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(trigOdd && trigEven));
  a_r5_parity_toggle: assert property (@(posedge clk) disable iff (!rstN)
    syncMarker |=> (baseTurn != $past(baseTurn)));
  a_r5_no_bunch_on_base: assert property (@(posedge clk) disable iff (!rstN)
    baseTurn |-> (bunchHit == '0));
endmodule

// File: rtl/bunchSeqCtrl.sv
module bunchSeqCtrl
  import bunchSeqPkg::*;
#(
  parameter int NSLOT   = 12,
  parameter int WW      = 4,
  parameter int RST_CYC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSLOT-1:0] bunchHit,
  input  logic             zeroHit,
  input  logic [WW-1:0]    wideWidth,
  output seqStrobe_t       strobe,
  output logic             overlapErr
);
  localparam logic [WW-1:0] RST_LAST = WW'(RST_CYC - 1);

  seqState_t     state;
  logic [WW-1:0] phase;
  logic [WW-1:0] wLat;
  logic [WW-1:0] wEff;
  logic          chanEvenQ;
  logic          anyHit;
  logic          multiHit;
  logic          firstOdd;

  assign anyHit   = (|bunchHit) || zeroHit;
  assign multiHit = $countones(bunchHit) > 1;
  assign wEff     = (wideWidth == '0) ? WW'(1) : wideWidth;

  always_comb begin
    firstOdd = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (bunchHit[i]) firstOdd = (i % 2) == 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      phase      <= '0;
      wLat       <= WW'(1);
      chanEvenQ  <= 1'b0;
      overlapErr <= 1'b0;
    end else begin
      if (anyHit && ((state != S_IDLE) || multiHit)) overlapErr <= 1'b1;
      case (state)
        S_IDLE: if (anyHit) begin
          state     <= S_WIDE;
          phase     <= '0;
          wLat      <= wEff;
          chanEvenQ <= firstOdd && !zeroHit;
        end
        S_WIDE: if (phase == wLat - WW'(1)) begin
          state <= S_TRIG;
          phase <= '0;
        end else begin
          phase <= phase + WW'(1);
        end
        S_TRIG: begin
          state <= S_RST;
          phase <= '0;
        end
        default: if (phase == RST_LAST) begin
          state <= S_IDLE;
          phase <= '0;
        end else begin
          phase <= phase + WW'(1);
        end
      endcase
    end
  end

  always_comb begin
    strobe.narrow   = (state == S_WIDE) && (phase == '0);
    strobe.wide     = (state == S_WIDE);
    strobe.trig     = (state == S_TRIG);
    strobe.intReset = (state == S_RST);
    strobe.chanEven = chanEvenQ;
  end

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overlapErr |=> overlapErr);
  a_r8_busy_hit_flags: assert property (@(posedge clk) disable iff (!rstN)
    (anyHit && (state != S_IDLE)) |=> overlapErr);
  a_r3_trig_to_reset: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TRIG) |=> (state == S_RST));
endmodule

// File: rtl/bunchGateSeq.sv
module bunchGateSeq
  import bunchSeqPkg::*;
#(
  parameter int NSLOT      = 12,
  parameter int PBAR_SLOTS = 4,
  parameter int CW         = 12,
  parameter int BLW        = 4,
  parameter int WW         = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncMarker,
  input  logic                antiMode,
  input  logic [NSLOT-1:0]    slotEnable,
  input  logic [BLW-1:0]      batchLen,
  input  logic [WW-1:0]       wideWidth,
  input  logic [NSLOT*CW-1:0] slotDelays,
  input  logic [CW-1:0]       protonZero,
  input  logic [CW-1:0]       pbarZero,
  output logic                narrowGate,
  output logic                wideGate,
  output logic                trigOdd,
  output logic                trigEven,
  output logic                integReset,
  output logic                baseTurn,
  output logic                overlapErr
);
  seqStrobe_t       strobe;
  logic [NSLOT-1:0] bunchHit;
  logic             zeroHit;

  bunchSeqPath #(
    .NSLOT(NSLOT), .PBAR_SLOTS(PBAR_SLOTS), .CW(CW), .BLW(BLW)
  ) uPath (
    .clk(clk), .rstN(rstN), .syncMarker(syncMarker), .antiMode(antiMode),
    .slotEnable(slotEnable), .batchLen(batchLen), .slotDelays(slotDelays),
    .protonZero(protonZero), .pbarZero(pbarZero), .strobe(strobe),
    .bunchHit(bunchHit), .zeroHit(zeroHit), .baseTurn(baseTurn),
    .narrowGate(narrowGate), .wideGate(wideGate), .trigOdd(trigOdd),
    .trigEven(trigEven), .integReset(integReset)
  );

  bunchSeqCtrl #(
    .NSLOT(NSLOT), .WW(WW), .RST_CYC(3)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bunchHit(bunchHit), .zeroHit(zeroHit),
    .wideWidth(wideWidth), .strobe(strobe), .overlapErr(overlapErr)
  );
endmodule

// File: tb/tb_bunchGateSeq.sv
module tb_bunchGateSeq;
  localparam int NSLOT = 12;
  localparam int CW    = 12;
  localparam int TURN  = 420;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, syncMarker, antiMode;
  logic [NSLOT-1:0] slotEnable;
  logic [3:0] batchLen, wideWidth;
  logic [NSLOT*CW-1:0] slotDelays;
  logic [CW-1:0] protonZero, pbarZero;
  logic [CW-1:0] dly [NSLOT];
  logic narrowGate, wideGate, trigOdd, trigEven, integReset, baseTurn, overlapErr;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) slotDelays[i*CW +: CW] = dly[i];
  end

  bunchGateSeq dut (
    .clk(clk), .rstN(rstN), .syncMarker(syncMarker), .antiMode(antiMode),
    .slotEnable(slotEnable), .batchLen(batchLen), .wideWidth(wideWidth),
    .slotDelays(slotDelays), .protonZero(protonZero), .pbarZero(pbarZero),
    .narrowGate(narrowGate), .wideGate(wideGate), .trigOdd(trigOdd),
    .trigEven(trigEven), .integReset(integReset), .baseTurn(baseTurn),
    .overlapErr(overlapErr)
  );

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  int    startAt [32];
  bit    startEven [32];
  int    nStart;
  int    errAt;
  bit    expErr = 1'b0;
  bit    expBase = 1'b0;
  bit    finished = 1'b0;

  task automatic check(string sig, string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: got %0b expected %0b", req, curReq, sig, act, exp);
    end
  endtask

  function automatic int wEff();
    return (wideWidth == 4'd0) ? 1 : int'(wideWidth);
  endfunction

  function automatic bit live(int i);
    return slotEnable[i] && (i < int'(batchLen)) && (!antiMode || i < 4);
  endfunction

  task automatic planTurn();
    int nextFree = -1000;
    nStart = 0;
    errAt  = -1;
    for (int c = 0; c < TURN; c++) begin
      int cand = 0;
      int first = -1;
      if (expBase) begin
        if (c == int'(antiMode ? pbarZero : protonZero)) begin
          cand = 1; first = 0;
        end
      end else begin
        for (int i = 0; i < NSLOT; i++) begin
          if (live(i) && int'(dly[i]) == c) begin
            cand++;
            if (first < 0) first = i;
          end
        end
      end
      if (cand > 0) begin
        if ((c < nextFree || cand > 1) && errAt < 0) errAt = c + 1;
        if (c >= nextFree) begin
          startAt[nStart]   = c;
          startEven[nStart] = (first % 2) == 1;
          nStart++;
          nextFree = c + wEff() + 5;
        end
      end
    end
  endtask

  task automatic runTurn();
    @(negedge clk);
    syncMarker = 1'b1;
    expBase = !expBase;
    planTurn();
    for (int k = 0; k < TURN; k++) begin
      bit eN = 0, eW = 0, eTo = 0, eTe = 0, eR = 0;
      int w = wEff();
      @(negedge clk);
      syncMarker = 1'b0;
      for (int s = 0; s < nStart; s++) begin
        int c = startAt[s];
        if (k == c + 2) eN = 1;
        if (k >= c + 2 && k <= c + w + 1) eW = 1;
        if (k == c + w + 2) begin
          if (startEven[s]) eTe = 1; else eTo = 1;
        end
        if (k >= c + w + 3 && k <= c + w + 5) eR = 1;
      end
      if (errAt >= 0 && k >= errAt) expErr = 1'b1;
      check("narrowGate", "R1", narrowGate, eN);
      check("wideGate", "R2", wideGate, eW);
      check("trigOdd", "R4", trigOdd, eTo);
      check("trigEven", "R4", trigEven, eTe);
      check("integReset", "R3", integReset, eR);
      check("baseTurn", "R5", baseTurn, expBase);
      check("overlapErr", "R8", overlapErr, expErr);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    syncMarker = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expErr = 1'b0;
    expBase = 1'b0;
  endtask

  task automatic spacedDelays(int gap, int first);
    int d = first;
    for (int i = 0; i < NSLOT; i++) begin
      dly[i] = CW'(d);
      d += gap;
    end
  endtask

  task automatic randomConfig();
    int d;
    wideWidth  = 4'($urandom % 16);
    antiMode   = ($urandom % 3) == 0;
    slotEnable = NSLOT'($urandom);
    batchLen   = 4'(1 + $urandom % 15);
    protonZero = CW'($urandom % 380);
    pbarZero   = CW'($urandom % 380);
    d = int'($urandom % 10);
    for (int i = 0; i < NSLOT; i++) begin
      dly[i] = CW'(d);
      if (($urandom % 6) == 0) d += wEff() + 2 + int'($urandom % 4);
      else d += wEff() + 5 + int'($urandom % 6);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; syncMarker = 1'b0; antiMode = 1'b0;
    slotEnable = '1; batchLen = 4'd12; wideWidth = 4'd3;
    protonZero = 12'd5; pbarZero = 12'd9;
    spacedDelays(25, 0);
    repeat (3) @(negedge clk);

    // R9: reset state
    curReq = "R9";
    check("narrowGate", "R9", narrowGate, 1'b0);
    check("baseTurn", "R9", baseTurn, 1'b0);
    check("overlapErr", "R9", overlapErr, 1'b0);
    rstN = 1'b1;
    // R9: no sequence before first sync, delay 0 programmed
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check("wideGate", "R9", wideGate, 1'b0);
      check("trigOdd", "R9", trigOdd, 1'b0);
      check("integReset", "R9", integReset, 1'b0);
    end

    // R6: first turn is a baseline turn, proton zero time
    curReq = "R6";
    runTurn();
    // R1 R2 R3 R4: full twelve-slot proton batch
    curReq = "R1";
    runTurn();
    // R6: antiproton zero time on baseline turn
    curReq = "R6";
    antiMode = 1'b1;
    runTurn();
    // R7: antiproton mode keeps only slots 0..3
    curReq = "R7";
    runTurn();
    // R7: batch length and enable holes, proton mode
    antiMode = 1'b0; batchLen = 4'd5; slotEnable = 12'b1111_1110_1101;
    runTurn(); runTurn();
    // R2: width 0 acts as 1
    curReq = "R2";
    slotEnable = '1; batchLen = 4'd15; wideWidth = 4'd0;
    runTurn(); runTurn();
    // R8: width 15 at exactly W+5 spacing, legal
    curReq = "R8";
    wideWidth = 4'd15;
    spacedDelays(20, 3);
    runTurn(); runTurn();
    // R8: one bucket inside the limit
    dly[5] = dly[5] - 12'd1;
    runTurn(); runTurn();
    doReset();
    // R8: equal delays, lower index kept
    wideWidth = 4'd4;
    spacedDelays(22, 2);
    dly[4] = dly[3];
    runTurn(); runTurn();
    doReset();

    // random configurations
    curReq = "random";
    for (int n = 0; n < 24; n++) begin
      randomConfig();
      runTurn();
      runTurn();
      if (expErr) doReset();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule